// File: doc/BRIEF.md
# Link Bus Grant Sequencer (PHY Side)

This block sits on the PHY side of a 4-bit PHY-to-link interface and runs the transmit-side ownership handshake. The link raises a request. The block then waits for an arbitration-won indication from arbitration logic outside this block. When that arrives, the block drives the grant code on the shared control lines, then idle for one turnaround cycle, and then releases both the control and data lines to the link.

While the link owns the bus, the block decodes the control code the link drives. A hold code keeps the bus reserved: the block reports a data-on condition toward the cable side. A transmit code carries a data nibble, which the block forwards toward the cable side. An idle code ends the transfer: the block takes the lines back and drives its own idle.

A hold that directly follows packet data asks for a chained packet. In that case the block waits a fixed number of clocks and grants again without a new arbitration. The cable speed captured at arbitration stays in force for the whole chain. An illegal code from the link is handled as idle and reported with an error flag.

Top module: `lgs_top`

## Requirements
- R1: After reset the block drives the lines (`phy_drive_o`=1) with control 00 and data 0000. Nibble-valid, data-on and error outputs are 0, and the latched speed is 0.
- R2: Arbitration won while a request is pending gives GRANT_CYC cycles (default 1) of control 11 with data 0000. One cycle of control 00 with data 0000 follows, and after that `phy_drive_o` falls to 0.
- R3: Without a prior link request, `arb_won_i` has no effect: control stays 00 and the lines stay driven. A request with no arbitration win also keeps control at 00.
- R4: A hold code (01) from the link while it owns the bus sets `cable_dataon_o` in the following cycle.
- R5: A transmit code (10) from the link while it owns the bus presents that cycle's `link_dat_i` on `cable_nib_o` in the following cycle, with `cable_nib_vld_o`=1. In every other case valid is 0 and the nibble is 0000.
- R6: An idle code (00) that follows link activity makes the block drive again in the next cycle. It drives control 00 with data 0000 and keeps driving idle afterwards.
- R7: A hold code right after transmit data releases nothing back: for WAIT_CYC cycles (default 4) the lines stay undriven with `cable_dataon_o`=1. Then control 11 is driven for one cycle and 00 for one cycle, and the lines are released again. No arbitration input is needed for this.
- R8: `cable_speed_o` takes the value of `arb_speed_i` at the arbitration win. It holds that value through every chained packet, whatever `arb_speed_i` does later.
- R9: Code 11 from the link while it owns the bus raises `ctl_err_o` for the following cycle and otherwise acts as the idle code.
- R10: Idle or code 11 seen before the link has driven hold or transmit does not end link ownership; the lines stay undriven.
- R11: Link control and data are ignored during the re-grant wait: no nibble is forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_req_i | input | 1 | Bus request from the link |
| arb_won_i | input | 1 | Arbitration has been won |
| arb_speed_i | input | SPD_W | Speed code settled during arbitration |
| link_ctl_i | input | 2 | Control code driven by the link (00 idle, 01 hold, 10 transmit, 11 illegal) |
| link_dat_i | input | NIB_W | Data nibble driven by the link |
| phy_ctl_o | output | 2 | Control code driven by the block (00 idle, 11 grant) |
| phy_dat_o | output | NIB_W | Data driven by the block, always zero |
| phy_drive_o | output | 1 | Block drives the control and data lines |
| cable_nib_o | output | NIB_W | Nibble forwarded toward the cable side |
| cable_nib_vld_o | output | 1 | Forwarded nibble is valid |
| cable_dataon_o | output | 1 | Bus held for the link (data-on) |
| cable_speed_o | output | SPD_W | Speed latched at arbitration |
| ctl_err_o | output | 1 | Illegal link control code seen |

## Verification
A wrong ownership state shows up on `phy_drive_o` and `phy_ctl_o` in the same cycle. These outputs are decoded directly from the state, so a grant that comes too early or too late, or a missed release, is visible on the next clock edge. A fault in the re-grant wait counter moves the 11 code earlier or later by whole cycles, and the bench catches it by counting the undriven data-on cycles. Faults in the forwarding path or in the speed latch appear one cycle after the link code that caused them.

// File: rtl/lgs_pkg.sv
package lgs_pkg;

    typedef enum logic [1:0] {
        LC_IDLE = 2'b00,
        LC_HOLD = 2'b01,
        LC_XMIT = 2'b10,
        LC_BAD  = 2'b11
    } lnk_code_e;

    typedef enum logic [1:0] {
        PC_IDLE  = 2'b00,
        PC_GRANT = 2'b11
    } phy_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUESTED,
        ST_GRANT,
        ST_TURNAROUND,
        ST_LINK_OWNED,
        ST_REGRANT_WAIT,
        ST_END_IDLE
    } seq_state_e;

endpackage

// File: rtl/lgs_seq_fsm.sv
module lgs_seq_fsm
    import lgs_pkg::*;
#(
    parameter int GRANT_CYC = 1,
    parameter int WAIT_CYC  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       won_i,
    input  logic [1:0] lctl_i,
    output seq_state_e st_o,
    output logic       dataon_o
);
    localparam int CNT_MAX = (WAIT_CYC > GRANT_CYC) ? WAIT_CYC : GRANT_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] GRANT_LAST = CNT_W'(GRANT_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(WAIT_CYC - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             pkt;
        logic             regrant;
        logic             dataon;
    } seq_t;

    seq_t seq_d, seq_q;
    lnk_code_e code;

    always_comb begin
        code  = lnk_code_e'(lctl_i);
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_i) seq_d.st = ST_REQUESTED;
            end
            ST_REQUESTED: begin
                if (won_i) begin
                    seq_d.st      = ST_GRANT;
                    seq_d.cnt     = '0;
                    seq_d.regrant = 1'b0;
                end
            end
            ST_GRANT: begin
                if (seq_q.regrant || seq_q.cnt == GRANT_LAST) begin
                    seq_d.st  = ST_TURNAROUND;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_TURNAROUND: begin
                seq_d.st     = ST_LINK_OWNED;
                seq_d.active = 1'b0;
                seq_d.pkt    = 1'b0;
            end
            ST_LINK_OWNED: begin
                unique case (code)
                    LC_HOLD: begin
                        if (seq_q.pkt) begin
                            seq_d.st  = ST_REGRANT_WAIT;
                            seq_d.cnt = '0;
                        end else begin
                            seq_d.active = 1'b1;
                        end
                    end
                    LC_XMIT: begin
                        seq_d.active = 1'b1;
                        seq_d.pkt    = 1'b1;
                    end
                    default: begin
                        if (seq_q.active) seq_d.st = ST_END_IDLE;
                    end
                endcase
            end
            ST_REGRANT_WAIT: begin
                if (seq_q.cnt == WAIT_LAST) begin
                    seq_d.st      = ST_GRANT;
                    seq_d.cnt     = '0;
                    seq_d.regrant = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_END_IDLE: begin
                seq_d.st = ST_IDLE;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
        seq_d.dataon = (seq_d.st == ST_REGRANT_WAIT) ||
                       (seq_q.st == ST_LINK_OWNED && code == LC_HOLD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cnt: '0, active: 1'b0, pkt: 1'b0,
                       regrant: 1'b0, dataon: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st_o     = seq_q.st;
    assign dataon_o = seq_q.dataon;

endmodule

// File: rtl/lgs_fwd.sv
module lgs_fwd
    import lgs_pkg::*;
#(
    parameter int NIB_W = 4,
    parameter int SPD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             owned_i,
    input  logic             take_i,
    input  logic [1:0]       lctl_i,
    input  logic [NIB_W-1:0] ldat_i,
    input  logic [SPD_W-1:0] spd_i,
    output logic [NIB_W-1:0] nib_o,
    output logic             vld_o,
    output logic             err_o,
    output logic [SPD_W-1:0] spd_o
);
    typedef struct packed {
        logic [NIB_W-1:0] nib;
        logic             vld;
        logic             err;
        logic [SPD_W-1:0] spd;
    } fwd_t;

    fwd_t fwd_d, fwd_q;
    lnk_code_e code;

    always_comb begin
        code      = lnk_code_e'(lctl_i);
        fwd_d     = fwd_q;
        fwd_d.vld = owned_i && (code == LC_XMIT);
        fwd_d.nib = fwd_d.vld ? ldat_i : '0;
        fwd_d.err = owned_i && (code == LC_BAD);
        if (take_i) fwd_d.spd = spd_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_q <= '0;
        end else begin
            fwd_q <= fwd_d;
        end
    end

    assign nib_o = fwd_q.nib;
    assign vld_o = fwd_q.vld;
    assign err_o = fwd_q.err;
    assign spd_o = fwd_q.spd;

endmodule

// File: rtl/lgs_busdrv.sv
module lgs_busdrv
    import lgs_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  seq_state_e       st_i,
    output logic [1:0]       ctl_o,
    output logic [NIB_W-1:0] dat_o,
    output logic             drive_o
);
    always_comb begin
        drive_o = !(st_i == ST_LINK_OWNED || st_i == ST_REGRANT_WAIT);
        ctl_o   = (st_i == ST_GRANT) ? PC_GRANT : PC_IDLE;
        dat_o   = '0;
    end

endmodule

// File: rtl/lgs_top.sv
module lgs_top
    import lgs_pkg::*;
#(
    parameter int NIB_W     = 4,
    parameter int SPD_W     = 2,
    parameter int GRANT_CYC = 1,
    parameter int WAIT_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_req_i,
    input  logic             arb_won_i,
    input  logic [SPD_W-1:0] arb_speed_i,
    input  logic [1:0]       link_ctl_i,
    input  logic [NIB_W-1:0] link_dat_i,
    output logic [1:0]       phy_ctl_o,
    output logic [NIB_W-1:0] phy_dat_o,
    output logic             phy_drive_o,
    output logic [NIB_W-1:0] cable_nib_o,
    output logic             cable_nib_vld_o,
    output logic             cable_dataon_o,
    output logic [SPD_W-1:0] cable_speed_o,
    output logic             ctl_err_o
);
    seq_state_e seq_st;
    logic       owned;
    logic       take;

    lgs_seq_fsm #(.GRANT_CYC(GRANT_CYC), .WAIT_CYC(WAIT_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (link_req_i),
        .won_i    (arb_won_i),
        .lctl_i   (link_ctl_i),
        .st_o     (seq_st),
        .dataon_o (cable_dataon_o)
    );

    assign owned = (seq_st == ST_LINK_OWNED);
    assign take  = (seq_st == ST_REQUESTED) && arb_won_i;

    lgs_fwd #(.NIB_W(NIB_W), .SPD_W(SPD_W)) u_fwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .owned_i (owned),
        .take_i  (take),
        .lctl_i  (link_ctl_i),
        .ldat_i  (link_dat_i),
        .spd_i   (arb_speed_i),
        .nib_o   (cable_nib_o),
        .vld_o   (cable_nib_vld_o),
        .err_o   (ctl_err_o),
        .spd_o   (cable_speed_o)
    );

    lgs_busdrv #(.NIB_W(NIB_W)) u_drv (
        .st_i    (seq_st),
        .ctl_o   (phy_ctl_o),
        .dat_o   (phy_dat_o),
        .drive_o (phy_drive_o)
    );

endmodule

// File: rtl/lgs_chk.sv
module lgs_chk
    import lgs_pkg::*;
#(
    parameter int NIB_W    = 4,
    parameter int SPD_W    = 2,
    parameter int WAIT_CYC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       link_ctl_i,
    input logic [1:0]       phy_ctl_o,
    input logic [NIB_W-1:0] phy_dat_o,
    input logic             phy_drive_o,
    input logic             cable_nib_vld_o,
    input logic             cable_dataon_o,
    input logic [SPD_W-1:0] cable_speed_o,
    input logic             ctl_err_o,
    input seq_state_e       seq_st
);
    logic [15:0] wait_run;

    always_ff @(posedge clk) begin
        if (!rst_n) wait_run <= '0;
        else if (seq_st == ST_REGRANT_WAIT) wait_run <= wait_run + 1'b1;
        else wait_run <= '0;
    end

    // R2
    grant_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_ctl_o == 2'b11) |-> (phy_drive_o && phy_dat_o == '0));

    // R2
    grant_then_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_ctl_o == 2'b11) |=> (phy_ctl_o == 2'b11 ||
                                  (phy_drive_o && phy_ctl_o == 2'b00)));

    // R4
    dataon_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cable_dataon_o |-> !phy_drive_o);

    // R5
    vld_from_xmit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cable_nib_vld_o |-> ($past(link_ctl_i) == 2'b10 && !cable_dataon_o));

    // R6
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_END_IDLE) |-> (phy_drive_o && phy_ctl_o == 2'b00));

    // R7
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_REGRANT_WAIT) |-> (wait_run < 16'(WAIT_CYC)));

    // R7
    wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == ST_REGRANT_WAIT) |=>
            (seq_st == ST_REGRANT_WAIT ||
             (seq_st == ST_GRANT && wait_run == 16'(WAIT_CYC))));

    // R8
    speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st != ST_REQUESTED) |=> $stable(cable_speed_o));

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_err_o |-> ($past(link_ctl_i) == 2'b11));

endmodule

bind lgs_top lgs_chk #(.NIB_W(NIB_W), .SPD_W(SPD_W), .WAIT_CYC(WAIT_CYC)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .link_ctl_i      (link_ctl_i),
    .phy_ctl_o       (phy_ctl_o),
    .phy_dat_o       (phy_dat_o),
    .phy_drive_o     (phy_drive_o),
    .cable_nib_vld_o (cable_nib_vld_o),
    .cable_dataon_o  (cable_dataon_o),
    .cable_speed_o   (cable_speed_o),
    .ctl_err_o       (ctl_err_o),
    .seq_st          (seq_st)
);

// File: tb/lgs_top_tb_top.sv
`timescale 1ns/1ps
module lgs_top_tb_top;
    localparam int NIB_W = 4;
    localparam int SPD_W = 2;
    localparam int WAIT_CYC = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             link_req_i = 1'b0;
    logic             arb_won_i = 1'b0;
    logic [SPD_W-1:0] arb_speed_i = '0;
    logic [1:0]       link_ctl_i = 2'b00;
    logic [NIB_W-1:0] link_dat_i = '0;
    logic [1:0]       phy_ctl_o;
    logic [NIB_W-1:0] phy_dat_o;
    logic             phy_drive_o;
    logic [NIB_W-1:0] cable_nib_o;
    logic             cable_nib_vld_o;
    logic             cable_dataon_o;
    logic [SPD_W-1:0] cable_speed_o;
    logic             ctl_err_o;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lgs_top #(.NIB_W(NIB_W), .SPD_W(SPD_W), .GRANT_CYC(1), .WAIT_CYC(WAIT_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .link_req_i(link_req_i), .arb_won_i(arb_won_i),
        .arb_speed_i(arb_speed_i), .link_ctl_i(link_ctl_i), .link_dat_i(link_dat_i),
        .phy_ctl_o(phy_ctl_o), .phy_dat_o(phy_dat_o), .phy_drive_o(phy_drive_o),
        .cable_nib_o(cable_nib_o), .cable_nib_vld_o(cable_nib_vld_o),
        .cable_dataon_o(cable_dataon_o), .cable_speed_o(cable_speed_o),
        .ctl_err_o(ctl_err_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // bus state packed as {drive, ctl[1:0], dat}
    function automatic int bus();
        return {phy_drive_o, phy_ctl_o, phy_dat_o};
    endfunction

    localparam int BUS_IDLE  = 32'h40;
    localparam int BUS_GRANT = 32'h70;

    task automatic grant_seq(input int spd);
        link_req_i = 1'b1;
        tick();
        chk("R3 request pending, no win", bus(), BUS_IDLE);
        link_req_i = 1'b0;
        tick();
        chk("R3 no win keeps idle", bus(), BUS_IDLE);
        arb_won_i = 1'b1;
        arb_speed_i = SPD_W'(spd);
        tick();
        arb_won_i = 1'b0;
        arb_speed_i = SPD_W'(spd + 1);
        chk("R2 grant code", bus(), BUS_GRANT);
        tick();
        chk("R2 turnaround idle", bus(), BUS_IDLE);
        chk("R8 speed latched", int'(cable_speed_o), spd);
        tick();
        chk("R2 released", int'(phy_drive_o), 0);
    endtask

    task automatic send_pkt(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            link_ctl_i = 2'b10;
            link_dat_i = NIB_W'(seed + i * 7);
            tick();
            chk("R5 nibble", int'(cable_nib_o), (seed + i * 7) & 15);
            chk("R5 valid", int'(cable_nib_vld_o), 1);
        end
    endtask

    task automatic end_xfer();
        link_ctl_i = 2'b00;
        tick();
        chk("R6 retake idle", bus(), BUS_IDLE);
        chk("R5 valid drops", int'(cable_nib_vld_o), 0);
        tick();
        chk("R6 stays idle", bus(), BUS_IDLE);
    endtask

    initial begin
        int wcount;
        int bad_vld;
        repeat (3) tick();
        chk("R1 reset bus", bus(), BUS_IDLE);
        chk("R1 reset flags", {cable_nib_vld_o, cable_dataon_o, ctl_err_o}, 0);
        chk("R1 reset speed", int'(cable_speed_o), 0);
        rst_n = 1'b1;
        tick();

        // R3: win without request
        arb_won_i = 1'b1;
        link_ctl_i = 2'b10;
        repeat (3) tick();
        chk("R3 win ignored", bus(), BUS_IDLE);
        chk("R3 no forward", int'(cable_nib_vld_o), 0);
        arb_won_i = 1'b0;
        link_ctl_i = 2'b00;
        tick();

        // sweep of packet lengths, prep-hold and speeds
        for (int len = 1; len <= 16; len++) begin
            grant_seq(len % 4);
            link_ctl_i = 2'b00;
            tick();
            chk("R10 early idle keeps link owner", int'(phy_drive_o), 0);
            if (len % 2 == 1) begin
                link_ctl_i = 2'b01;
                tick();
                chk("R4 dataon on hold", int'(cable_dataon_o), 1);
                chk("R4 still released", int'(phy_drive_o), 0);
            end
            send_pkt(len, len * 3);
            chk("R4 dataon off in transmit", int'(cable_dataon_o), 0);
            end_xfer();
        end

        // chained packets
        for (int chains = 1; chains <= 3; chains++) begin
            grant_seq(chains);
            for (int k = 0; k < chains; k++) begin
                send_pkt(2 + k, 5 * k + chains);
                link_ctl_i = 2'b01;
                tick();
                link_ctl_i = 2'b10;
                link_dat_i = 4'hA;
                arb_speed_i = SPD_W'(chains + 2);
                wcount = 0;
                bad_vld = 0;
                while (!phy_drive_o && cable_dataon_o && wcount < 20) begin
                    if (cable_nib_vld_o) bad_vld++;
                    wcount++;
                    tick();
                end
                chk("R7 wait length", wcount, WAIT_CYC);
                chk("R11 no forward during wait", bad_vld, 0);
                chk("R7 regrant code", bus(), BUS_GRANT);
                link_ctl_i = 2'b00;
                tick();
                chk("R7 regrant idle", bus(), BUS_IDLE);
                tick();
                chk("R7 released again", int'(phy_drive_o), 0);
                chk("R8 speed kept in chain", int'(cable_speed_o), chains);
            end
            send_pkt(3, chains);
            end_xfer();
        end

        // R9: illegal code handling
        grant_seq(2);
        link_ctl_i = 2'b11;
        tick();
        chk("R9 err flag early", int'(ctl_err_o), 1);
        chk("R10 illegal early keeps owner", int'(phy_drive_o), 0);
        send_pkt(1, 9);
        chk("R9 err clears", int'(ctl_err_o), 0);
        link_ctl_i = 2'b11;
        tick();
        chk("R9 err flag", int'(ctl_err_o), 1);
        chk("R9 treated as idle", bus(), BUS_IDLE);
        link_ctl_i = 2'b00;
        tick();
        chk("R9 err pulse ends", int'(ctl_err_o), 0);
        chk("R6 idle after illegal end", bus(), BUS_IDLE);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule